// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Burst SRAM

This block is a single-port synchronous memory of 32-bit words. Its control interface decodes one command on every rising clock edge: begin a read burst, begin a write burst, continue the burst in progress, deselect, or hold the edge. Reads are flow-through. The word chosen at an edge appears on the data output during the cycle that follows, and a separate enable tells the surrounding pad logic when to drive the bus.

Write data trails its command by one edge. A read command can therefore follow a write command on the very next edge with no idle cycle on the shared data bus. Bursts step through four consecutive words. Only the low two address bits count, and they wrap. Each byte lane has its own active-low write enable. A clock enable can freeze the whole block. A sleep input forces the bus off at any time.

A synchronous active-low reset stands in for power-up. It leaves the block deselected with the bus released.

Top module: `zbt_ft_sram`

## Requirements
- R1: After reset, and on an edge with advance/load high while no burst is open (continue-deselect), `dout_en` is low and nothing is written.
- R2: An enabled edge with `adv_ld` low and any select inactive (`cs1_n` high, `cs2_n` high or `cs3` low) ends the burst. The bus is then off, and later `adv_ld`-high edges neither read nor write.
- R3: An enabled edge with `adv_ld` low, all selects active and `we_n` high starts a read at `addr`. In the following cycle `dout` is the stored word and `dout_en` is high while `oe_n` is low.
- R4: For a write command (`we_n` low) accepted at one edge, the data on `din` at the next enabled edge is stored. A read command at that same next edge, to that address, returns the newly written word.
- R5: On edges with `adv_ld` high during a burst, `we_n` is ignored. The burst keeps the direction chosen at its first edge.
- R6: Each continue edge adds one to the low two bits of the burst address, modulo 4, and keeps the upper bits. A burst started at 0x0D visits 0x0D, 0x0E, 0x0F, 0x0C, 0x0D.
- R7: The byte enables `be_n` are sampled with each write command and are active low. Bit 0 guards din[7:0], bit 1 guards din[15:8], bit 2 guards din[23:16] and bit 3 guards din[31:24]. Unselected bytes keep their old value.
- R8: A write command with `be_n` = 4'b1111 changes no byte, and the burst address still advances.
- R9: `oe_n` acts without a clock. While it is high `dout_en` is low. A read cycle with `oe_n` high still advances the burst address.
- R10: An edge with `cke_n` high changes no state and writes nothing. The output keeps showing the same word, and a pending write lands at the next enabled edge with that edge's data.
- R11: While `sleep` is high, `dout_en` is low with no clock needed. An edge with `sleep` high ends any burst and drops a pending write.
- R12: During write cycles `dout_en` stays low whatever `oe_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cs1_n | input | 1 | Select, active low |
| cs2_n | input | 1 | Select, active low |
| cs3 | input | 1 | Select, active high |
| adv_ld | input | 1 | High: advance burst; low: load new command |
| we_n | input | 1 | High: read burst, low: write burst (sampled at load) |
| be_n | input | 4 | Active-low byte write enables |
| cke_n | input | 1 | Active-low clock enable |
| sleep | input | 1 | Snooze, forces bus off |
| oe_n | input | 1 | Active-low output enable |
| addr | input | AW | Word address for load commands |
| din | input | 32 | Write data, one edge after its command |
| dout | output | 32 | Flow-through read data |
| dout_en | output | 1 | Output driver enable |

## Verification
Four-beat bursts are written and read back from starting addresses whose low bits are not zero. The wrap then shows as a drop of the low bits with the upper bits held, which tells a correct wrap apart from a carry into bit 2 or a plain increment. During the continue beats, `we_n` is flipped to the opposite value, which separates a latched direction from a live one. A masked write burst combines a one-lane enable, an all-high abort and a two-lane enable over a prefilled region. Reading it back separates lane mapping errors from stray writes. Stalls and sleep are placed in the middle of read bursts and of write bursts, and the word seen afterwards shows whether state moved or a pending write escaped.

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram #(
  parameter int AW = 8,
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs1_n,
  input  logic          cs2_n,
  input  logic          cs3,
  input  logic          adv_ld,
  input  logic          we_n,
  input  logic [NB-1:0] be_n,
  input  logic          cke_n,
  input  logic          sleep,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en
);

  logic [DW-1:0] mem [DEPTH];
  logic          active, dir_rd, op_rd, op_wr;
  logic [AW-1:0] op_addr;
  logic [NB-1:0] op_ben;

  wire sel   = !cs1_n && !cs2_n && cs3;
  wire start = !adv_ld && sel;
  wire cont  = adv_ld && active;
  wire busy  = start || cont;
  wire rd_nx = start ? we_n : dir_rd;

  wire [AW-1:0] addr_nx = start ? addr
                                : {op_addr[AW-1:2], op_addr[1:0] + 2'd1};

  always_ff @(posedge clk) begin
    if (!rst_n || sleep) begin
      active  <= 1'b0;
      op_rd   <= 1'b0;
      op_wr   <= 1'b0;
      dir_rd  <= 1'b0;
      op_addr <= '0;
      op_ben  <= '1;
    end else if (!cke_n) begin
      active  <= busy;
      op_rd   <= busy && rd_nx;
      op_wr   <= busy && !rd_nx;
      dir_rd  <= rd_nx;
      op_addr <= addr_nx;
      op_ben  <= be_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !sleep && !cke_n && op_wr) begin
      for (int b = 0; b < NB; b++) begin
        if (!op_ben[b]) mem[op_addr][8*b +: 8] <= din[8*b +: 8];
      end
    end
  end

  assign dout    = mem[op_addr];
  assign dout_en = op_rd && !oe_n && !sleep;

endmodule

// File: rtl/zbt_ft_sram_chk.sv
module zbt_ft_sram_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs1_n,
  input logic          adv_ld,
  input logic          cke_n,
  input logic          sleep,
  input logic          oe_n,
  input logic          dout_en,
  input logic          active,
  input logic          op_rd,
  input logic          op_wr,
  input logic [AW-1:0] op_addr
);

  // R2
  deselect_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !sleep && !adv_ld && cs1_n) |=> (!op_rd && !op_wr && !active));

  // R6
  burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !sleep && adv_ld && active) |=>
      ((op_addr[1:0] == $past(op_addr[1:0]) + 2'd1) &&
       (op_addr[AW-1:2] == $past(op_addr[AW-1:2]))));

  // R9
  oe_gates_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  // R10
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_n && !sleep) |=> ($stable(op_addr) && $stable(op_rd) &&
                           $stable(op_wr) && $stable(active)));

  // R11
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

  // R11
  sleep_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!active && !op_wr));

  // R12
  write_bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_wr |-> (!dout_en && !op_rd));

endmodule

bind zbt_ft_sram zbt_ft_sram_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .adv_ld(adv_ld),
  .cke_n(cke_n), .sleep(sleep), .oe_n(oe_n), .dout_en(dout_en),
  .active(active), .op_rd(op_rd), .op_wr(op_wr), .op_addr(op_addr)
);

// File: tb/zbt_ft_sram_tb.sv
module zbt_ft_sram_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs1_n = 1'b1, cs2_n = 1'b0, cs3 = 1'b1;
  logic adv_ld = 1'b0, we_n = 1'b1, cke_n = 1'b0, sleep = 1'b0, oe_n = 1'b0;
  logic [3:0]  be_n = 4'hF;
  logic [7:0]  addr = '0;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic        dout_en;

  int n_chk = 0;
  int n_fail = 0;

  bit          q_chk[$];
  bit          q_en[$];
  bit          q_cd[$];
  logic [31:0] q_d[$];
  string       q_r[$];

  localparam logic [2:0] SEL = 3'b001;
  localparam logic [2:0] DES = 3'b101;

  always #4 clk = ~clk;

  zbt_ft_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3),
    .adv_ld(adv_ld), .we_n(we_n), .be_n(be_n), .cke_n(cke_n),
    .sleep(sleep), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic cmd(input logic [2:0] cs, input logic adv, input logic wen,
                     input logic [3:0] be, input logic [7:0] a,
                     input logic [31:0] d);
    {cs1_n, cs2_n, cs3} = cs;
    adv_ld = adv; we_n = wen; be_n = be; addr = a; din = d;
  endtask

  task automatic step(input bit en, input bit cd, input logic [31:0] d,
                      input string r);
    q_chk.push_back(1'b1); q_en.push_back(en); q_cd.push_back(cd);
    q_d.push_back(d); q_r.push_back(r);
    @(negedge clk);
  endtask

  task automatic skip();
    q_chk.push_back(1'b0); q_en.push_back(1'b0); q_cd.push_back(1'b0);
    q_d.push_back('0); q_r.push_back("");
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_chk.size() > 0) begin
        bit c, e, cdv;
        logic [31:0] dv;
        string rv;
        c = q_chk.pop_front(); e = q_en.pop_front(); cdv = q_cd.pop_front();
        dv = q_d.pop_front(); rv = q_r.pop_front();
        if (c) begin
          n_chk++;
          if (dout_en !== e) begin
            n_fail++;
            $display("FAIL %s: dout_en actual %b expected %b", rv, dout_en, e);
          end else if (cdv && dout !== dv) begin
            n_fail++;
            $display("FAIL %s: dout actual %h expected %h", rv, dout, dv);
          end
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung, expected finished run");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    skip();
    step(1'b0, 1'b0, '0, "R1");
    rst_n = 1'b1;
    cmd(DES, 1, 1, 4'hF, 8'h00, '0);  step(0, 0, '0, "R1");

    // write burst at 0x0E, direction held while we_n flips
    cmd(SEL, 0, 0, 4'h0, 8'h0E, '0);           step(0, 0, '0, "R12");
    cmd(SEL, 1, 1, 4'h0, 8'h77, 32'hA0000000); step(0, 0, '0, "R5");
    cmd(SEL, 1, 1, 4'h0, 8'h00, 32'hA1111111); step(0, 0, '0, "R12");
    cmd(SEL, 1, 0, 4'h0, 8'h00, 32'hA2222222); step(0, 0, '0, "R12");
    cmd(DES, 0, 1, 4'h0, 8'h00, 32'hA3333333); step(0, 0, '0, "R2");
    cmd(SEL, 1, 0, 4'h0, 8'h00, 32'hDEADBEEF); step(0, 0, '0, "R2");

    // read burst at 0x0D wraps through 0x0E,0x0F,0x0C,0x0D
    cmd(SEL, 0, 1, 4'hF, 8'h0D, '0);  step(1, 1, 32'hA3333333, "R3");
    cmd(SEL, 1, 0, 4'hF, 8'h00, '0);  step(1, 1, 32'hA0000000, "R5");
    cmd(SEL, 1, 1, 4'hF, 8'h00, '0);  step(1, 1, 32'hA1111111, "R6");
    step(1, 1, 32'hA2222222, "R6");
    step(1, 1, 32'hA3333333, "R6");
    oe_n = 1'b1;                       step(0, 0, '0, "R9");
    oe_n = 1'b0;                       step(1, 1, 32'hA1111111, "R9");
    cke_n = 1'b1;
    cmd(SEL, 0, 1, 4'hF, 8'h20, '0);  step(1, 1, 32'hA1111111, "R10");
    cke_n = 1'b0;
    cmd(SEL, 1, 1, 4'hF, 8'h00, '0);  step(1, 1, 32'hA2222222, "R10");
    sleep = 1'b1;                      step(0, 0, '0, "R11");
    sleep = 1'b0;                      step(0, 0, '0, "R11");

    // prefill 0x20..0x23, then masked burst, then read at once
    cmd(SEL, 0, 0, 4'h0, 8'h20, '0);           step(0, 0, '0, "R12");
    cmd(SEL, 1, 1, 4'h0, 8'h00, 32'h01010101); step(0, 0, '0, "R4");
    cmd(SEL, 1, 1, 4'h0, 8'h00, 32'h02020202); step(0, 0, '0, "R4");
    cmd(SEL, 1, 1, 4'h0, 8'h00, 32'h03030303); step(0, 0, '0, "R4");
    cmd(SEL, 0, 0, 4'h0, 8'h20, 32'h04040404); step(0, 0, '0, "R4");
    cmd(SEL, 1, 1, 4'b1110, 8'h00, 32'h11223344); step(0, 0, '0, "R7");
    cmd(SEL, 1, 1, 4'b1111, 8'h00, 32'h55667788); step(0, 0, '0, "R8");
    cmd(SEL, 1, 1, 4'b0101, 8'h00, 32'h99AABBCC); step(0, 0, '0, "R8");
    cmd(SEL, 0, 1, 4'hF, 8'h23, 32'hDDEEFF00);    step(1, 1, 32'hDD04FF04, "R4");
    cmd(SEL, 1, 1, 4'hF, 8'h00, '0);  step(1, 1, 32'h11223344, "R7");
    step(1, 1, 32'h02020288, "R7");
    step(1, 1, 32'h03030303, "R8");

    // stall in the middle of a write
    cmd(SEL, 0, 0, 4'h0, 8'h30, '0);           step(0, 0, '0, "R12");
    cke_n = 1'b1;
    cmd(SEL, 1, 1, 4'h0, 8'h00, 32'hBAD0BAD0); step(0, 0, '0, "R10");
    cke_n = 1'b0;
    cmd(SEL, 1, 1, 4'h0, 8'h00, 32'h5A5A0F0F); step(0, 0, '0, "R10");
    cmd(SEL, 0, 1, 4'hF, 8'h30, '0);           step(1, 1, 32'h5A5A0F0F, "R10");

    // sleep drops a pending write
    cmd(SEL, 0, 0, 4'h0, 8'h40, '0);           step(0, 0, '0, "R12");
    cmd(DES, 0, 1, 4'hF, 8'h00, 32'hC0DEC0DE); step(0, 0, '0, "R2");
    cmd(SEL, 0, 0, 4'h0, 8'h40, '0);           step(0, 0, '0, "R12");
    sleep = 1'b1;
    cmd(SEL, 1, 1, 4'hF, 8'h00, 32'hFFFFFFFF); step(0, 0, '0, "R11");
    sleep = 1'b0;
    cmd(SEL, 0, 1, 4'hF, 8'h40, '0);           step(1, 1, 32'hC0DEC0DE, "R11");

    // each select alone deselects
    cmd(3'b011, 0, 1, 4'hF, 8'h40, '0);  step(0, 0, '0, "R2");
    cmd(3'b000, 0, 1, 4'hF, 8'h40, '0);  step(0, 0, '0, "R2");
    cmd(SEL, 0, 1, 4'hF, 8'h40, '0);     step(1, 1, 32'hC0DEC0DE, "R3");
    cmd(DES, 0, 1, 4'hF, 8'h00, '0);     step(0, 0, '0, "R2");
    skip();
    skip();
    wait (q_chk.size() == 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule